// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI host read and write a bank of 64 registers, each 24 bits wide. Every access is a single 32-bit frame framed by an active-high chip select. The frame carries a write flag, a 6-bit register offset and a 24-bit data field. While the host is still clocking in the data field, the slave is already shifting out the addressed register's current value. A read therefore finishes in one transfer, and a write frame returns the value the register held before the write.

On the core side the block drives a plain register-file port: an offset, write data and a one-cycle write strobe, plus a combinational read-data return. All three SPI inputs pass through a shared synchronizer into the system clock domain. The serial clock must therefore run at no more than one eighth of the system clock. The block handles framing, offset capture, launch of the read data and the write commit at the end of the frame. It does not hold the register contents.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame runs from the rising to the falling edge of `cs_i` (active high). MOSI is sampled on rising SCLK edges, and MISO changes only after falling SCLK edges (mode 0). SCLK activity while `cs_i` is low has no effect.
- R2: Frame bit 31, the first bit sent, selects the access: 1 writes and 0 reads.
- R3: Frame bits 30:25 give the register offset. Every offset from 0 to 63 can be reached, and it is presented on `reg_addr_o`.
- R4: Frame bits 23:0 are the write data. Frame bit 24 is ignored on both reads and writes.
- R5: In the same frame, MISO returns the addressed register's 24-bit value MSB first in frame bits 23:0. Frame bits 31:24 on MISO are zero.
- R6: A write is committed as a single-cycle `reg_we_o` pulse after `cs_i` falls, and only if exactly 32 SCLK rising edges were seen. A frame that is shorter or longer produces no strobe.
- R7: A read frame never strobes `reg_we_o`.
- R8: A write frame returns on MISO the register value as it was before that write.
- R9: After reset, and whenever no frame is in progress, `miso_o` is low and `reg_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_i | input | 1 | SPI chip select, active high |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| reg_addr_o | output | ADDR_W | Register offset of the current frame |
| reg_wdata_o | output | DATA_W | Write data for the commit |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | DATA_W | Register value at `reg_addr_o` (combinational) |

## Verification
The final falling SCLK edge, which would shift MISO, and the falling edge of chip select, which clears MISO and commits the write, can reach the core in the same synchronized cycle. Some frames lower SCLK and chip select at the same instant to provoke this. The check is that the write strobe still fires exactly once with the right offset and data, and that MISO is low afterwards. A later read-back confirms that the register file holds the new value.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned DEF_ADDR_W = 6;
  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_SYNC   = 2;

  // flag + offset + one ignored bit + data
  function automatic int unsigned frame_w(int unsigned aw, int unsigned dw);
    return 1 + aw + 1 + dw;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned CNT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_ld_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned ADDR_DONE = 1 + ADDR_W;  // bits in before offset complete
  localparam int unsigned CNT_SAT   = FRAME_W + 1; // marks an over-long frame

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, rx_nxt;
  logic [ADDR_W-1:0]  addr_q;
  logic               addr_ld_q, we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               commit;

  assign rx_nxt = {rx_q[FRAME_W-2:0], mosi_i};
  assign commit = cs_fall_i && (cnt_q == CNT_W'(FRAME_W)) && rx_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rx_q      <= '0;
      addr_q    <= '0;
      addr_ld_q <= 1'b0;
    end else begin
      addr_ld_q <= 1'b0;
      if (cs_rise_i || cs_fall_i) begin
        cnt_q <= '0;
        if (cs_rise_i) rx_q <= '0;
      end else if (sclk_rise_i) begin
        rx_q <= rx_nxt;
        if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ADDR_DONE - 1)) begin
          addr_q    <= rx_nxt[ADDR_W-1:0];
          addr_ld_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= commit;
      if (commit) wdata_q <= rx_q[DATA_W-1:0];
    end
  end

  assign bit_cnt_o = cnt_q;
  assign addr_o    = addr_q;
  assign addr_ld_o = addr_ld_q;
  assign we_o      = we_q;
  assign wdata_o   = wdata_q;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned HDR_W   = 8,
  parameter int unsigned CNT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_edge_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              sclk_fall_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  output logic              miso_o
);
  logic [DATA_W-1:0] tx_q;
  logic              out_q;
  logic              in_data;

  // falling edge after bit (cnt) received launches frame bit FRAME_W-1-cnt
  assign in_data = (bit_cnt_i >= CNT_W'(HDR_W)) && (bit_cnt_i < CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      out_q <= 1'b0;
    end else if (cs_edge_i) begin
      out_q <= 1'b0;
    end else begin
      if (load_i) tx_q <= rdata_i;
      if (sclk_fall_i) begin
        if (in_data) begin
          out_q <= tx_q[DATA_W-1];
          tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          out_q <= 1'b0;
        end
      end
    end
  end

  assign miso_o = out_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned FRAME_W = frame_w(ADDR_W, DATA_W);
  localparam int unsigned HDR_W   = FRAME_W - DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, mosi_s;
  logic             cs_d, sclk_d;
  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic             addr_ld;

  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sclk_i, mosi_i}),
    .q_o    (pins_s)
  );

  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign sclk_rise = cs_s & sclk_s & ~sclk_d;
  assign sclk_fall = cs_s & ~sclk_s & sclk_d;

  spi_rx_frame #(
    .FRAME_W (FRAME_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
  ) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_rise_i   (cs_rise),
    .cs_fall_i   (cs_fall),
    .sclk_rise_i (sclk_rise),
    .mosi_i      (mosi_s),
    .bit_cnt_o   (bit_cnt),
    .addr_o      (reg_addr_o),
    .addr_ld_o   (addr_ld),
    .we_o        (reg_we_o),
    .wdata_o     (reg_wdata_o)
  );

  spi_tx_shift #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W),
    .HDR_W   (HDR_W),
    .CNT_W   (CNT_W)
  ) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_edge_i   (cs_rise | cs_fall),
    .load_i      (addr_ld),
    .rdata_i     (reg_rdata_i),
    .sclk_fall_i (sclk_fall),
    .bit_cnt_i   (bit_cnt),
    .miso_o      (miso_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned HDR_W   = 8,
  parameter int unsigned CNT_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             cs_d,
  input logic             cs_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             reg_we_o,
  input logic             miso_o
);
  // R6
  we_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R6
  we_full_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ($past(cs_fall) && ($past(bit_cnt) == CNT_W'(FRAME_W))));

  // R9
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !cs_d) |-> !miso_o);

  // R5
  miso_header_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt < CNT_W'(HDR_W)) |-> !miso_o);

  // R1
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !cs_d) |=> $stable(bit_cnt));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .FRAME_W (FRAME_W),
  .HDR_W   (HDR_W),
  .CNT_W   (CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .cs_d     (cs_d),
  .cs_fall  (cs_fall),
  .bit_cnt  (bit_cnt),
  .reg_we_o (reg_we_o),
  .miso_o   (miso_o)
);

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;
  localparam int HALF = 40;  // SCLK half period, 10 system clocks
  localparam int GAP  = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [5:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic        reg_we;

  logic [23:0] mem     [64];
  logic [23:0] exp_mem [64];
  logic [29:0] exp_wr_q [$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic        we_prev = 1'b0;

  always #2 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sclk_i      (sclk),
    .cs_i        (cs),
    .mosi_i      (mosi),
    .miso_o      (miso),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  // external register file
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: write commits
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (we_prev) chk(1'b0, "R6 strobe longer than one cycle", 32'd1, 32'd0);
        else if (exp_wr_q.size() == 0) chk(1'b0, "R6/R7 unexpected write strobe", {2'b0, reg_addr, reg_wdata}, 32'd0);
        else begin
          logic [29:0] e;
          e = exp_wr_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R6 commit offset/data", {2'b0, reg_addr, reg_wdata}, {2'b0, e});
        end
      end
      we_prev <= reg_we;
    end
  end

  task automatic xfer(input logic [31:0] word, input int nbits, input bit tight, output logic [31:0] got);
    got = '0;
    cs = 1'b1;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? word[31-i] : 1'b0;
      #(HALF);
      sclk = 1'b1;
      got = {got[30:0], miso};
      #(HALF);
      sclk = 1'b0;
      if (tight && i == nbits - 1) cs = 1'b0;
    end
    if (!tight) begin
      #(HALF);
      cs = 1'b0;
    end
    mosi = 1'b0;
    #(GAP);
    chk(miso == 1'b0, "R9 miso idle after frame", {31'b0, miso}, 32'd0);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [23:0] d, input logic b24, input bit tight);
    logic [31:0] got, exp;
    exp = {8'h00, exp_mem[a]};
    exp_wr_q.push_back({a, d});
    exp_mem[a] = d;
    xfer({1'b1, a, b24, d}, 32, tight, got);
    chk(got == exp, "R8 write frame returns old value", got, exp);
  endtask

  task automatic do_read(input logic [5:0] a, input logic b24, input logic [23:0] junk);
    logic [31:0] got, exp;
    exp = {8'h00, exp_mem[a]};
    xfer({1'b0, a, b24, junk}, 32, 1'b0, got);
    chk(got == exp, "R5/R3 read data in same frame", got, exp);
  endtask

  initial begin
    logic [31:0] g;
    for (int i = 0; i < 64; i++) begin
      mem[i]     = 24'h5A0000 ^ (24'(i) * 24'h010203);
      exp_mem[i] = 24'h5A0000 ^ (24'(i) * 24'h010203);
    end
    repeat (4) @(negedge clk);
    chk(miso == 1'b0 && reg_we == 1'b0, "R9 reset state", {30'b0, miso, reg_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R5: reads across offsets incl. boundaries
    do_read(6'd5, 1'b0, 24'h000000);
    do_read(6'd0, 1'b0, 24'hFFFFFF);
    do_read(6'd63, 1'b0, 24'h123456);
    do_read(6'd42, 1'b0, 24'h000000);

    // R2 R8: writes at boundaries, read back
    do_write(6'd63, 24'hA5C3F0, 1'b0, 1'b0);
    do_read(6'd63, 1'b0, 24'h0);
    do_write(6'd0, 24'hFFFFFF, 1'b0, 1'b0);
    do_write(6'd1, 24'h000000, 1'b0, 1'b0);
    do_write(6'd2, 24'h800001, 1'b0, 1'b0);
    do_read(6'd0, 1'b0, 24'h0);
    do_read(6'd1, 1'b0, 24'h0);
    do_read(6'd2, 1'b0, 24'h0);

    // R4: bit 24 ignored on write and read
    do_write(6'd10, 24'h0F0F0F, 1'b1, 1'b0);
    do_read(6'd10, 1'b1, 24'hABCDEF);
    do_read(6'd11, 1'b1, 24'hFFFFFF);

    // R7: read frame with data field set leaves register intact
    do_read(6'd12, 1'b0, 24'h654321);
    do_read(6'd12, 1'b0, 24'h0);

    // R6: short frame dropped
    xfer({1'b1, 6'd20, 1'b0, 24'h111111}, 31, 1'b0, g);
    do_read(6'd20, 1'b0, 24'h0);
    // R6: long frame dropped
    xfer({1'b1, 6'd21, 1'b0, 24'h222222}, 33, 1'b0, g);
    do_read(6'd21, 1'b0, 24'h0);

    // R1: chip select dropped together with last SCLK fall
    do_write(6'd30, 24'hC0FFEE, 1'b0, 1'b1);
    do_read(6'd30, 1'b0, 24'h0);

    // R1: SCLK toggling with chip select low is ignored
    for (int i = 0; i < 40; i++) begin
      mosi = 1'b1;
      #(HALF) sclk = 1'b1;
      #(HALF) sclk = 1'b0;
    end
    mosi = 1'b0;
    #(GAP);
    chk(miso == 1'b0, "R1 idle SCLK no effect on miso", {31'b0, miso}, 32'd0);
    do_read(6'd30, 1'b0, 24'h0);

    chk(exp_wr_q.size() == 0, "R6 missing write commit", exp_wr_q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule